// File: doc/BRIEF.md
# Bus Hold and Priority Arbiter

This block decides who owns a shared external bus. Three parties compete for it: an external device that requests a hold on an active-low line, a DMA controller, and the CPU. The priority is fixed. Hold wins over DMA, and DMA wins over CPU. Ownership changes only at access boundaries. A boundary is the cycle in which the bus cycle generator reports that an access is complete, or a cycle in which the current owner is not requesting. When no one else wants the bus, the CPU owns it.

While the bus is held, the block drives the hold-acknowledge output low. It also deasserts a driver enable, which the pad logic uses to float the address, data, chip-select, read, write and byte-high lines. The bus clock is not gated by this block and keeps running.

A CPU word access to an odd address takes two bus cycles. Neither DMA nor hold can take the bus between those two halves. The hold input is asynchronous, so it passes through a synchronizer before the arbiter uses it. When hold ends, there is one settle cycle in which the drivers come back on before the next owner is granted.

Top module: `bus_owner_arb`

## Requirements
- R1: During and right after reset, `gnt_cpu`=1, `gnt_dma`=0 and `gnt_hold`=0, with `hold_ack_n`=1 and `bus_drv_en`=1.
- R2: At a boundary the next owner is chosen in this order: hold if the synchronized hold request is active, else DMA if `dma_req`=1, else CPU.
- R3: A CPU or DMA owner that is requesting keeps the bus in every cycle where `acc_done`=0.
- R4: A low level on `hold_req_n` reaches the arbiter through `SYNC_STAGES` flops. With the default of 2, a level applied before clock edge k can grant hold no earlier than edge k+2.
- R5: Hold stays granted as long as the synchronized hold request stays active. While hold is granted, `hold_ack_n`=0 and `bus_drv_en`=0. Outside hold, both are 1.
- R6: When hold ends, there is exactly one cycle with no grant, `hold_ack_n`=1 and `bus_drv_en`=1. Arbitration takes place at the end of that cycle.
- R7: A CPU access that completes with `cpu_word`=1 and `cpu_addr0`=1 is the first half of a split. The CPU keeps the bus until the next `acc_done`, even if DMA is requesting.
- R8: At most one of `gnt_hold`, `gnt_dma`, `gnt_cpu` is 1 in any cycle.
- R9: A hold request that arrives during a split is granted only at the edge where the second half completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Asynchronous external hold request, active low |
| dma_req | input | 1 | DMA controller requests the bus |
| cpu_req | input | 1 | CPU requests the bus |
| cpu_word | input | 1 | Current CPU access is a word access |
| cpu_addr0 | input | 1 | Address LSB of the current CPU access |
| acc_done | input | 1 | Bus cycle generator reports that the current access is complete |
| gnt_hold | output | 1 | External hold owns the bus |
| gnt_dma | output | 1 | DMA owns the bus |
| gnt_cpu | output | 1 | CPU owns the bus |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| bus_drv_en | output | 1 | Enable for the external address, data and strobe drivers |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. Its model can therefore count exactly two edges of synchronizer latency before a hold request is able to win a boundary. With this depth, a hold request can land in the middle of a split access, during the release cycle, or in the same cycle as a completion. Random acc_done timing combined with random word/odd flags produces back-to-back splits, and slow random toggling of hold exercises release cycles that arbitrate straight back into hold.

// File: rtl/bus_owner_arb.sv
module bus_owner_arb #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic dma_req,
  input  logic cpu_req,
  input  logic cpu_word,
  input  logic cpu_addr0,
  input  logic acc_done,
  output logic gnt_hold,
  output logic gnt_dma,
  output logic gnt_cpu,
  output logic hold_ack_n,
  output logic bus_drv_en
);

  typedef enum logic [1:0] {OWN_CPU, OWN_DMA, OWN_HOLD, OWN_SETTLE} own_t;

  logic [SYNC_STAGES-1:0] hsync;
  logic                   hold_s;
  own_t                   own, own_nxt, pick;
  logic                   split, split_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hsync <= '0;
    else        hsync <= {hsync[SYNC_STAGES-2:0], ~hold_req_n};

  assign hold_s = hsync[SYNC_STAGES-1];
  assign pick   = hold_s ? OWN_HOLD : (dma_req ? OWN_DMA : OWN_CPU);

  always_comb begin
    own_nxt   = own;
    split_nxt = split;
    case (own)
      OWN_CPU:
        if (split) begin
          if (acc_done) begin
            split_nxt = 1'b0;
            own_nxt   = pick;
          end
        end else if (acc_done && cpu_word && cpu_addr0) begin
          split_nxt = 1'b1;
        end else if (acc_done || !cpu_req) begin
          own_nxt = pick;
        end
      OWN_DMA:    if (acc_done || !dma_req) own_nxt = pick;
      OWN_HOLD:   if (!hold_s) own_nxt = OWN_SETTLE;
      OWN_SETTLE: own_nxt = pick;
      default:    own_nxt = OWN_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      own   <= OWN_CPU;
      split <= 1'b0;
    end else begin
      own   <= own_nxt;
      split <= split_nxt;
    end

  assign gnt_hold   = (own == OWN_HOLD);
  assign gnt_dma    = (own == OWN_DMA);
  assign gnt_cpu    = (own == OWN_CPU);
  assign hold_ack_n = (own != OWN_HOLD);
  assign bus_drv_en = (own != OWN_HOLD);

endmodule

module bus_owner_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_req,
  input logic cpu_req,
  input logic acc_done,
  input logic gnt_hold,
  input logic gnt_dma,
  input logic gnt_cpu,
  input logic hold_ack_n,
  input logic bus_drv_en,
  input logic split
);

  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_hold, gnt_dma, gnt_cpu}));

  assert_hold_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_hold |-> (!hold_ack_n && !bus_drv_en));

  assert_settle_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_hold) |-> (hold_ack_n && bus_drv_en && !gnt_dma && !gnt_cpu));

  assert_dma_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_dma && dma_req && !acc_done) |=> gnt_dma);

  assert_cpu_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_cpu && cpu_req && !acc_done) |=> gnt_cpu);

  assert_split_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    split |-> gnt_cpu);

endmodule

bind bus_owner_arb bus_owner_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .cpu_req(cpu_req),
  .acc_done(acc_done), .gnt_hold(gnt_hold), .gnt_dma(gnt_dma),
  .gnt_cpu(gnt_cpu), .hold_ack_n(hold_ack_n), .bus_drv_en(bus_drv_en),
  .split(split)
);

// File: tb/bus_owner_arb_test.sv
module bus_owner_arb_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_req_n = 1'b1, dma_req = 1'b0, cpu_req = 1'b0;
  logic cpu_word = 1'b0, cpu_addr0 = 1'b0, acc_done = 1'b0;
  logic gnt_hold, gnt_dma, gnt_cpu, hold_ack_n, bus_drv_en;

  int total = 0, bad = 0;
  string phase = "R1 reset";
  int m_own = 0;
  logic m_half = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_owner_arb uut (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .dma_req(dma_req),
    .cpu_req(cpu_req), .cpu_word(cpu_word), .cpu_addr0(cpu_addr0),
    .acc_done(acc_done), .gnt_hold(gnt_hold), .gnt_dma(gnt_dma),
    .gnt_cpu(gnt_cpu), .hold_ack_n(hold_ack_n), .bus_drv_en(bus_drv_en)
  );

  function automatic int choose(logic hs, logic dreq);
    return hs ? 2 : (dreq ? 1 : 0);
  endfunction

  task automatic check(string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("gnt_cpu",    gnt_cpu,    m_own == 0);
    check("gnt_dma",    gnt_dma,    m_own == 1);
    check("gnt_hold",   gnt_hold,   m_own == 2);
    check("hold_ack_n", hold_ack_n, m_own != 2);
    check("bus_drv_en", bus_drv_en, m_own != 2);
  endtask

  task automatic model_edge();
    logic hs;
    int p;
    hs   = m_s2;
    m_s2 = m_s1;
    m_s1 = !hold_req_n;
    p    = choose(hs, dma_req);
    case (m_own)
      0: if (m_half) begin
           if (acc_done) begin m_half = 1'b0; m_own = p; end
         end else if (acc_done && cpu_word && cpu_addr0) m_half = 1'b1;
         else if (acc_done || !cpu_req) m_own = p;
      1: if (acc_done || !dma_req) m_own = p;
      2: if (!hs) m_own = 3;
      default: m_own = p;
    endcase
  endtask

  task automatic cyc(logic h_n, logic d, logic c, logic w, logic a0, logic done);
    @(negedge clk);
    compare();
    hold_req_n = h_n; dma_req = d; cpu_req = c;
    cpu_word = w; cpu_addr0 = a0; acc_done = done;
    model_edge();
  endtask

  initial begin
    repeat (CLK_PERIOD * 30000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic h;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();
    rst_n = 1'b1;

    // R7: odd word split, DMA waits for second half
    phase = "R7 split vs dma";
    cyc(1, 0, 1, 1, 1, 0);
    cyc(1, 1, 1, 1, 1, 1);
    repeat (4) cyc(1, 1, 1, 1, 1, 0);
    cyc(1, 1, 1, 1, 1, 1);
    repeat (3) cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 1);

    // R9: hold arrives mid-split, granted only after second half; R6 settle then
    phase = "R9 hold in split";
    cyc(1, 0, 1, 1, 1, 0);
    cyc(1, 1, 1, 1, 1, 1);
    cyc(0, 1, 1, 1, 1, 0);
    repeat (5) cyc(0, 1, 1, 1, 1, 0);
    cyc(0, 1, 1, 1, 1, 1);
    phase = "R5 R6 hold and release";
    repeat (4) cyc(0, 1, 1, 0, 0, 0);
    repeat (5) cyc(1, 1, 1, 0, 0, 0);
    repeat (2) cyc(1, 0, 1, 0, 0, 1);

    // R4: short pulse timing
    phase = "R4 sync latency";
    cyc(0, 0, 0, 0, 0, 0);
    repeat (6) cyc(1, 0, 0, 0, 0, 0);

    phase = "R2 R3 R4 R5 R6 R7 R8 R9 random";
    void'($urandom(32'd1234));
    h = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) h = ~h;
      cyc(h, $urandom_range(0, 9) < 4, $urandom_range(0, 9) < 8,
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    @(negedge clk);
    compare();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule